// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Core

This block is the digital front end of a two-channel 12-bit converter. It acts as a three-wire serial slave with an active-low select, a serial clock and a data line. A frame carries a 16-bit command, most significant bit first. Each command names one of four targets: the channel A code, the channel B code, a shared staging register, or the reference control. Every command also carries the speed bit and the power-down bit.

The three serial pins are brought into the system clock through synchronizers, and their edges are detected there. All register state therefore changes in one clock domain. The staging register lets software load the next channel B code in advance. A single later command then writes channel A and moves the staged value into channel B on the same clock edge, so both outputs change together. Each channel has a one-cycle strobe that pulses on every write to its code latch.

Top module: `dac_serial_regcore`

## Requirements
- R1: After reset, both codes, the reference select, the speed flag, the power-down flag and both strobes are zero.
- R2: A frame starts on a falling edge of `cs_n`. Data is sampled on falling `sclk` edges, most significant bit first. In the 16-bit word, bit 15 is select-high, bit 12 is select-low, bit 14 is speed (1 = fast), bit 13 is power-down (1 = down), and bits 11..0 are data.
- R3: Select 00 writes the data into both `code_b` and the staging register.
- R4: Select 01 writes the staging register only. `code_a` and `code_b` do not change.
- R5: Select 10 writes the data into `code_a` and, on the same clock edge, copies the staging register into `code_b`.
- R6: Select 11 loads `ref_sel` from data bits 1..0 (00 and 11 external, 01 low internal, 10 high internal). Data bits 11..2 are ignored, and both codes stay unchanged.
- R7: `fast_mode` and `pwr_down` are taken from every accepted word, whatever the select.
- R8: A word is accepted at the 16th falling `sclk` edge. Any further `sclk` edges before `cs_n` rises are ignored.
- R9: If `cs_n` rises after 1 to 15 bits, the partial word is accepted with its missing low bits taken as zero. If `cs_n` rises after no bits, nothing changes.
- R10: `upd_a` and `upd_b` each go high for exactly one clock per write to their channel's latch, in the cycle the new code appears.
- R11: Edges on `sclk` while `cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sdin | input | 1 | Serial data |
| code_a | output | 12 | Channel A latched code |
| code_b | output | 12 | Channel B latched code |
| ref_sel | output | 2 | Reference selection field |
| fast_mode | output | 1 | 1 = fast settling mode |
| pwr_down | output | 1 | 1 = power-down requested |
| upd_a | output | 1 | One-cycle pulse on a channel A latch write |
| upd_b | output | 1 | One-cycle pulse on a channel B latch write |

## Verification
The hardest cases to reach from the ports are the truncated frame and the extra clocks after a complete word. The stimulus reaches them by deliberately misbehaving on `cs_n`. It raises select after every bit count from zero to fifteen, and it keeps `sclk` running for several bits past sixteen with data that would change the result if it were taken. The simultaneous transfer is reached by interleaving staging-only commands with channel A commands, so the expected `code_b` after a select-10 command comes from an earlier frame.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 12;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    SEL_B_STAGE = 2'b00,
    SEL_STAGE   = 2'b01,
    SEL_A_XFER  = 2'b10,
    SEL_CTRL    = 2'b11
  } sel_e;

  // Field layout follows the serial order: bit 15 first on the wire.
  typedef struct packed {
    logic              sel_hi;
    logic              fast;
    logic              pdn;
    logic              sel_lo;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic a;
    logic b;
    logic b_from_stage;
    logic stage;
    logic ctrl;
  } wr_t;

  function automatic sel_e cmd_sel(input cmd_t c);
    return sel_e'({c.sel_hi, c.sel_lo});
  endfunction

  function automatic wr_t cmd_decode(input cmd_t c);
    wr_t w;
    w = '0;
    unique case (cmd_sel(c))
      SEL_B_STAGE: begin w.b = 1'b1; w.stage = 1'b1; end
      SEL_STAGE:   w.stage = 1'b1;
      SEL_A_XFER:  begin w.a = 1'b1; w.b = 1'b1; w.b_from_stage = 1'b1; end
      SEL_CTRL:    w.ctrl = 1'b1;
      default:     w = '0;
    endcase
    return w;
  endfunction

  // Pad a short frame: the n received bits move to the top, zeros fill below.
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] sh,
                                                  input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] gap;
    gap = CNT_W'(WORD_W) - n;
    return sh << gap;
  endfunction
endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
  parameter int             N       = 3,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg_q[STAGES-1];

  assign lvl  = stg_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/dacreg_shifter.sv
module dacreg_shifter
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              din,
  output logic              word_stb,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              take_bit;
  logic [WORD_W-1:0] sh_next;

  assign take_bit = sclk_fall && !cs_lvl && !done_q;
  assign sh_next  = {sh_q[WORD_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b1;
      word_stb <= 1'b0;
      word     <= '0;
    end else begin
      word_stb <= 1'b0;
      if (cs_fall) begin
        sh_q   <= '0;
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (cs_rise) begin
        if (!done_q && cnt_q != '0) begin
          word_stb <= 1'b1;
          word     <= left_align(sh_q, cnt_q);
        end
        done_q <= 1'b1;
      end else if (take_bit) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          word_stb <= 1'b1;
          word     <= sh_next;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  assert_one_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && !cs_rise && sclk_fall) |=> !word_stb);
endmodule

// File: rtl/dacreg_bank.sv
module dacreg_bank
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic [1:0]        ref_sel,
  output logic              fast_mode,
  output logic              pwr_down,
  output logic              upd_a,
  output logic              upd_b
);
  cmd_t              cmd;
  wr_t               wr;
  logic [DATA_W-1:0] stage_q;

  assign cmd = cmd_t'(word);
  always_comb wr = word_stb ? cmd_decode(cmd) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a    <= '0;
      code_b    <= '0;
      stage_q   <= '0;
      ref_sel   <= '0;
      fast_mode <= 1'b0;
      pwr_down  <= 1'b0;
      upd_a     <= 1'b0;
      upd_b     <= 1'b0;
    end else begin
      upd_a <= wr.a;
      upd_b <= wr.b;
      if (wr.a)     code_a  <= cmd.data;
      if (wr.b)     code_b  <= wr.b_from_stage ? stage_q : cmd.data;
      if (wr.stage) stage_q <= cmd.data;
      if (wr.ctrl)  ref_sel <= cmd.data[1:0];
      if (word_stb) begin
        fast_mode <= cmd.fast;
        pwr_down  <= cmd.pdn;
      end
    end
  end

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && cmd_sel(cmd) == SEL_STAGE) |=> ($stable(code_a) && $stable(code_b)));

  assert_xfer_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && cmd_sel(cmd) == SEL_A_XFER) |=> (code_b == $past(stage_q)));

  assert_ctrl_keeps_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && cmd_sel(cmd) == SEL_CTRL) |=> ($stable(code_a) && $stable(code_b)));

  assert_strobe_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_a || upd_b) |-> $past(word_stb));

  assert_quiet_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_a |-> $stable(code_a));
endmodule

// File: rtl/dac_serial_regcore.sv
module dac_serial_regcore
  import dacreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic [1:0]        ref_sel,
  output logic              fast_mode,
  output logic              pwr_down,
  output logic              upd_a,
  output logic              upd_b
);
  localparam int PINS = 3;
  localparam int P_CS = 2;
  localparam int P_CK = 1;
  localparam int P_DI = 0;

  logic [PINS-1:0]   pin_lvl, pin_rise, pin_fall;
  logic              word_stb;
  logic [WORD_W-1:0] word;

  dacreg_sync #(
    .N      (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS'(1) << P_CS)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({cs_n, sclk, sdin}),
    .lvl     (pin_lvl),
    .rise    (pin_rise),
    .fall    (pin_fall)
  );

  dacreg_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (pin_lvl[P_CS]),
    .cs_fall  (pin_fall[P_CS]),
    .cs_rise  (pin_rise[P_CS]),
    .sclk_fall(pin_fall[P_CK]),
    .din      (pin_lvl[P_DI]),
    .word_stb (word_stb),
    .word     (word)
  );

  dacreg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .word     (word),
    .code_a   (code_a),
    .code_b   (code_b),
    .ref_sel  (ref_sel),
    .fast_mode(fast_mode),
    .pwr_down (pwr_down),
    .upd_a    (upd_a),
    .upd_b    (upd_b)
  );

  assert_no_stb_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl[P_CS] && !pin_rise[P_CS]) |=> !word_stb);
endmodule

// File: tb/dac_serial_regcore_tb.sv
module dac_serial_regcore_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic [11:0] code_a, code_b;
  logic [1:0]  ref_sel;
  logic        fast_mode, pwr_down, upd_a, upd_b;

  int checks = 0;
  int failures = 0;
  int n_upd_a = 0, n_upd_b = 0;
  int e_upd_a = 0, e_upd_b = 0;

  logic [11:0] m_a = '0, m_b = '0, m_stage = '0;
  logic [1:0]  m_ref = '0;
  logic        m_fast = 1'b0, m_pd = 1'b0;

  localparam int HALF = 6;

  always #4 clk = ~clk;

  dac_serial_regcore u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .code_a(code_a), .code_b(code_b), .ref_sel(ref_sel),
    .fast_mode(fast_mode), .pwr_down(pwr_down), .upd_a(upd_a), .upd_b(upd_b)
  );

  always @(posedge clk) begin
    if (upd_a) n_upd_a <= n_upd_a + 1;
    if (upd_b) n_upd_b <= n_upd_b + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(code_a == m_a, req, "code_a", 32'(code_a), 32'(m_a));
    chk(code_b == m_b, req, "code_b", 32'(code_b), 32'(m_b));
    chk(ref_sel == m_ref, req, "ref_sel", 32'(ref_sel), 32'(m_ref));
    chk(fast_mode == m_fast, req, "fast_mode", 32'(fast_mode), 32'(m_fast));
    chk(pwr_down == m_pd, req, "pwr_down", 32'(pwr_down), 32'(m_pd));
    chk(n_upd_a == e_upd_a, "R10", "upd_a pulses", 32'(n_upd_a), 32'(e_upd_a));
    chk(n_upd_b == e_upd_b, "R10", "upd_b pulses", 32'(n_upd_b), 32'(e_upd_b));
  endtask

  // Reference model of an accepted word (R2..R7).
  task automatic model(input logic [15:0] w);
    logic [1:0]  s;
    logic [11:0] d;
    s = {w[15], w[12]};
    d = w[11:0];
    m_fast = w[14];
    m_pd   = w[13];
    case (s)
      2'b00: begin m_b = d; m_stage = d; e_upd_b++; end
      2'b01: m_stage = d;
      2'b10: begin m_a = d; m_b = m_stage; e_upd_a++; e_upd_b++; end
      default: m_ref = d[1:0];
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits bits; bits past 16 come from ~w so that taking them would show.
  task automatic frame(input logic [15:0] w, input int nbits);
    logic [15:0] kept;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 16) ? w[15 - i] : ~w[15 - (i % 16)];
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(12);
    if (nbits >= 16) model(w);
    else if (nbits > 0) begin
      kept = w & ~(16'hFFFF >> nbits);
      model(kept);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0]  sel_order [5];
    logic [11:0] pat;
    logic [15:0] w;
    string tag;
    sel_order[0] = 2'b01; sel_order[1] = 2'b10; sel_order[2] = 2'b00;
    sel_order[3] = 2'b10; sel_order[4] = 2'b11;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1: reset state
    check_all("R1");
    chk(!upd_a && !upd_b, "R1", "strobes idle", 32'({upd_a, upd_b}), 32'd0);

    // R2..R7: sweep selects, data patterns and mode bits
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 5; j++) begin
        pat = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : 12'((k * 12'h9A7 + j * 12'h135));
        w = {sel_order[j][1], 1'(k % 2), 1'((k / 2) % 2), sel_order[j][0], pat};
        frame(w, 16);
        case (sel_order[j])
          2'b00: tag = "R3";
          2'b01: tag = "R4";
          2'b10: tag = "R5";
          default: tag = "R6";
        endcase
        check_all(tag);
        check_all("R7");
      end
    end

    // R6: every reference code, with noise in the ignored data bits
    for (int r = 0; r < 4; r++) begin
      frame({4'b1001, 10'h2A5, 2'(r)}, 16);
      check_all("R6");
    end

    // R9: truncated frames of every length 0..15
    for (int n = 0; n < 16; n++) begin
      frame(16'hBCDE ^ 16'(n * 16'h1111), n);
      check_all("R9");
    end

    // R8: extra clocks after a full word
    for (int n = 17; n <= 21; n++) begin
      frame({4'b1000, 12'(n * 12'h0F3)}, n);
      check_all("R8");
      frame({4'b0100, 12'(n * 12'h1C5)}, n);
      check_all("R8");
    end

    // R11: clocks and data toggling with select high
    for (int i = 0; i < 20; i++) begin
      sdin = i[0];
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
    wait_clk(12);
    check_all("R11");

    // R5: staged value lands in B together with the A write
    frame(16'h1ABC, 16);
    frame(16'h8123, 16);
    check_all("R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule